// File: doc/BRIEF.md
# Sleep Mode Clock-Gating Controller

This block is the power-management unit of a small microcontroller core. The CPU issues a sleep strobe along with a sleep-enable bit and a 3-bit mode code. The controller then gates the clock enables of four domains: CPU, flash, I/O and ADC. Which domains stop depends on the chosen mode. On entry to the two lighter modes it can also fire a one-cycle ADC conversion start.

While the core sleeps, eight wake-up request lines are filtered against a per-mode permission mask. The interrupt-pin level request must persist for a parameterised number of cycles before it counts. When an allowed request arrives, the core clocks come back.

A software bit can switch off the brown-out detector for the length of a sleep. That bit can only be written through a two-step timed sequence. When the detector was off, the core clocks stay gated for a parameterised settling time after wake-up.

Top module: `sleep_clkgate_ctrl`

## Requirements
- R1: Out of reset the block is running: all four clock enables and `bod_en_o` are 1, `asleep_o` is 0 and `bod_sleep_o` is 0.
- R2: A strobe with `sleep_en_i`=1 and mode code 000 makes the next cycle drop the CPU and flash enables while the I/O and ADC enables stay 1. Codes 011 to 111 behave exactly like 000.
- R3: Mode code 001 leaves only the ADC enable at 1 while asleep.
- R4: Mode code 010 drops all four clock enables while asleep.
- R5: A strobe while `sleep_en_i`=0 has no effect. A strobe while already asleep has no effect.
- R6: Wake line bits are as follows:
  - 0: any other interrupt
  - 1: ADC done
  - 2: reset class
  - 3: serial start detect
  - 4: asynchronous timer
  - 5: store/EEPROM ready
  - 6: interrupt-pin level
  - 7: pin change

  Mode 000 accepts all eight lines. Mode 001 accepts every line but bit 0. Mode 010 accepts only bits 2, 3, 6 and 7. Lines a mode does not accept leave the core asleep.
- R7: `adc_start_o` is a single-cycle pulse in the first asleep cycle, only for modes 000 and 001 (including reserved codes) and only when `adc_enabled_i`=1.
- R8: If `bod_sleep_o` was 1 at entry, `bod_en_o` is 0 for the whole sleep. It returns to 1 the cycle after the wake. The core clocks then stay as in sleep for `BOD_SETTLE` further cycles, and wake lines are ignored during that time.
- R9: If `bod_sleep_o` was 0 at entry, all clocks return on the cycle after an accepted wake request.
- R10: `bod_sleep_o` changes only through this sequence:
  - a write with `bods_unlock_i`=1 opens a window;
  - a write with `bods_unlock_i`=0 in one of the next `UNLOCK_WIN` (4) cycles loads `bods_val_i`.

  Any other write is ignored.
- R11: Wake bit 6 is accepted only after it has been high for `LEVEL_HOLD` consecutive cycles. A shorter pulse never wakes the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Sleep mode code |
| sleep_en_i | input | 1 | Sleep enable |
| sleep_strobe_i | input | 1 | Sleep instruction strobe |
| bods_wr_i | input | 1 | Write strobe for the brown-out-sleep bit |
| bods_unlock_i | input | 1 | Unlock flag carried by the write |
| bods_val_i | input | 1 | Value to load into the brown-out-sleep bit |
| adc_enabled_i | input | 1 | ADC is enabled |
| wake_req_i | input | 8 | Wake request lines (R6) |
| clk_en_cpu_o | output | 1 | CPU clock enable |
| clk_en_flash_o | output | 1 | Flash clock enable |
| clk_en_io_o | output | 1 | I/O clock enable |
| clk_en_adc_o | output | 1 | ADC clock enable |
| bod_en_o | output | 1 | Brown-out detector enable |
| adc_start_o | output | 1 | ADC conversion start pulse |
| asleep_o | output | 1 | Core is asleep or settling |
| bod_sleep_o | output | 1 | Current brown-out-sleep bit |

## Verification
The bench builds the block with `BOD_SETTLE`=20 and `LEVEL_HOLD`=3 instead of the default 1200 and 4. At these values the full settling countdown and its end cycle can be compared cycle by cycle against the model. Level pulses of two and three cycles then sit on either side of the acceptance threshold. The unlock window keeps its real width of 4, so writes landing on the fourth and sixth cycle after the unlock probe both edges of the window.

// File: rtl/slp_pkg.sv
package slp_pkg;

    localparam int WAKE_N = 8;

    localparam int WK_ANY_IRQ   = 0;
    localparam int WK_ADC_DONE  = 1;
    localparam int WK_RESET     = 2;
    localparam int WK_SER_START = 3;
    localparam int WK_ASYNC_TMR = 4;
    localparam int WK_NVM_RDY   = 5;
    localparam int WK_PIN_LEVEL = 6;
    localparam int WK_PIN_CHG   = 7;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_SLEEP,
        ST_SETTLE
    } slp_state_e;

    typedef enum logic [1:0] {
        SM_IDLE,
        SM_ADC_QUIET,
        SM_PWR_DOWN
    } slp_mode_e;

    function automatic slp_mode_e decode_mode(input logic [2:0] code);
        case (code)
            3'b001:  return SM_ADC_QUIET;
            3'b010:  return SM_PWR_DOWN;
            default: return SM_IDLE;
        endcase
    endfunction

    function automatic logic [WAKE_N-1:0] wake_mask(input slp_mode_e m);
        logic [WAKE_N-1:0] msk;
        msk = '0;
        case (m)
            SM_IDLE: msk = '1;
            SM_ADC_QUIET: begin
                msk = '1;
                msk[WK_ANY_IRQ] = 1'b0;
            end
            default: begin
                msk[WK_RESET]     = 1'b1;
                msk[WK_SER_START] = 1'b1;
                msk[WK_PIN_LEVEL] = 1'b1;
                msk[WK_PIN_CHG]   = 1'b1;
            end
        endcase
        return msk;
    endfunction

endpackage

// File: rtl/slp_level_filter.sv
module slp_level_filter #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic qual_o
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] TOP = CW'(HOLD - 1);

    logic [CW-1:0] run_d, run_q;

    always_comb begin
        run_d = '0;
        if (raw_i) begin
            run_d = (run_q >= TOP) ? run_q : run_q + 1'b1;
        end
        qual_o = raw_i && (run_q >= TOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end
endmodule

// File: rtl/slp_bods_unlock.sv
module slp_bods_unlock #(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic unlock_i,
    input  logic val_i,
    output logic bods_o
);
    localparam int WW = $clog2(WIN + 1);

    typedef struct packed {
        logic [WW-1:0] win;
        logic          bods;
    } ulk_t;

    ulk_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            if (unlock_i) begin
                s_d.win = WW'(WIN);
            end else begin
                if (s_q.win != '0) begin
                    s_d.bods = val_i;
                end
                s_d.win = '0;
            end
        end else if (s_q.win != '0) begin
            s_d.win = s_q.win - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bods_o = s_q.bods;
endmodule

// File: rtl/sleep_clkgate_ctrl.sv
module sleep_clkgate_ctrl
    import slp_pkg::*;
#(
    parameter int                BOD_SETTLE = 1200,
    parameter int                LEVEL_HOLD = 4,
    parameter int                UNLOCK_WIN = 4,
    parameter logic [WAKE_N-1:0] LEVEL_MASK = 8'b0100_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic              sleep_en_i,
    input  logic              sleep_strobe_i,
    input  logic              bods_wr_i,
    input  logic              bods_unlock_i,
    input  logic              bods_val_i,
    input  logic              adc_enabled_i,
    input  logic [WAKE_N-1:0] wake_req_i,
    output logic              clk_en_cpu_o,
    output logic              clk_en_flash_o,
    output logic              clk_en_io_o,
    output logic              clk_en_adc_o,
    output logic              bod_en_o,
    output logic              adc_start_o,
    output logic              asleep_o,
    output logic              bod_sleep_o
);
    localparam int SW = (BOD_SETTLE > 1) ? $clog2(BOD_SETTLE) : 1;
    localparam logic [SW-1:0] SETTLE_LAST = SW'(BOD_SETTLE - 1);

    typedef struct packed {
        slp_state_e    state;
        slp_mode_e     mode;
        logic          bod_off;
        logic [SW-1:0] cnt;
        logic          adc_go;
    } ctl_t;

    ctl_t c_d, c_q;
    logic [WAKE_N-1:0] wake_ok;
    logic              bods_bit;
    slp_mode_e         req_mode;

    for (genvar i = 0; i < WAKE_N; i++) begin : g_wake
        if (LEVEL_MASK[i]) begin : g_lvl
            slp_level_filter #(.HOLD(LEVEL_HOLD)) u_flt (
                .clk    (clk),
                .rst_n  (rst_n),
                .raw_i  (wake_req_i[i]),
                .qual_o (wake_ok[i])
            );
        end else begin : g_edge
            assign wake_ok[i] = wake_req_i[i];
        end
    end

    slp_bods_unlock #(.WIN(UNLOCK_WIN)) u_ulk (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bods_wr_i),
        .unlock_i (bods_unlock_i),
        .val_i    (bods_val_i),
        .bods_o   (bods_bit)
    );

    assign req_mode = decode_mode(mode_i);

    always_comb begin
        c_d        = c_q;
        c_d.adc_go = 1'b0;
        case (c_q.state)
            ST_RUN: begin
                if (sleep_strobe_i && sleep_en_i) begin
                    c_d.state   = ST_SLEEP;
                    c_d.mode    = req_mode;
                    c_d.bod_off = bods_bit;
                    c_d.adc_go  = adc_enabled_i && (req_mode != SM_PWR_DOWN);
                end
            end
            ST_SLEEP: begin
                if (|(wake_ok & wake_mask(c_q.mode))) begin
                    if (c_q.bod_off) begin
                        c_d.state = ST_SETTLE;
                        c_d.cnt   = SETTLE_LAST;
                    end else begin
                        c_d.state = ST_RUN;
                    end
                end
            end
            default: begin
                if (c_q.cnt == '0) begin
                    c_d.state = ST_RUN;
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{state: ST_RUN, mode: SM_IDLE, bod_off: 1'b0, cnt: '0, adc_go: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        clk_en_cpu_o   = (c_q.state == ST_RUN);
        clk_en_flash_o = (c_q.state == ST_RUN);
        clk_en_io_o    = (c_q.state == ST_RUN) || (c_q.mode == SM_IDLE);
        clk_en_adc_o   = (c_q.state == ST_RUN) || (c_q.mode != SM_PWR_DOWN);
        bod_en_o       = !((c_q.state == ST_SLEEP) && c_q.bod_off);
        adc_start_o    = c_q.adc_go;
        asleep_o       = (c_q.state != ST_RUN);
        bod_sleep_o    = bods_bit;
    end
endmodule

// File: rtl/slp_ctrl_checker.sv
module slp_ctrl_checker (
    input logic clk,
    input logic rst_n,
    input logic sleep_strobe_i,
    input logic sleep_en_i,
    input logic bods_wr_i,
    input logic clk_en_cpu_o,
    input logic clk_en_flash_o,
    input logic clk_en_io_o,
    input logic clk_en_adc_o,
    input logic bod_en_o,
    input logic adc_start_o,
    input logic bod_sleep_o
);
    AST_CPU_FLASH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_cpu_o == clk_en_flash_o); // R2
    AST_IO_NEEDS_ADC: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_io_o |-> clk_en_adc_o); // R3
    AST_STROBE_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_cpu_o && sleep_strobe_i && !sleep_en_i) |=> clk_en_cpu_o); // R5
    AST_ADC_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |=> !adc_start_o); // R7
    AST_ADC_PULSE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |-> (!clk_en_cpu_o && clk_en_adc_o)); // R7
    AST_BOD_OFF_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !bod_en_o |-> !clk_en_cpu_o); // R8
    AST_BODS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !bods_wr_i |=> $stable(bod_sleep_o)); // R10
endmodule

bind sleep_clkgate_ctrl slp_ctrl_checker u_chk (.*);

// File: tb/sleep_clkgate_ctrl_bench.sv
module sleep_clkgate_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE = 20;
    localparam int HOLD   = 3;

    logic       clk = 0, rst_n = 0;
    logic [2:0] mode_i = 0;
    logic       sleep_en_i = 0, sleep_strobe_i = 0;
    logic       bods_wr_i = 0, bods_unlock_i = 0, bods_val_i = 0;
    logic       adc_enabled_i = 0;
    logic [7:0] wake_req_i = 0;
    logic       clk_en_cpu_o, clk_en_flash_o, clk_en_io_o, clk_en_adc_o;
    logic       bod_en_o, adc_start_o, asleep_o, bod_sleep_o;

    int tests = 0, fails = 0, cycles = 0;
    bit done = 0;

    sleep_clkgate_ctrl #(.BOD_SETTLE(SETTLE), .LEVEL_HOLD(HOLD)) u_sleep_clkgate_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sleep_en_i(sleep_en_i),
        .sleep_strobe_i(sleep_strobe_i), .bods_wr_i(bods_wr_i),
        .bods_unlock_i(bods_unlock_i), .bods_val_i(bods_val_i),
        .adc_enabled_i(adc_enabled_i), .wake_req_i(wake_req_i),
        .clk_en_cpu_o(clk_en_cpu_o), .clk_en_flash_o(clk_en_flash_o),
        .clk_en_io_o(clk_en_io_o), .clk_en_adc_o(clk_en_adc_o),
        .bod_en_o(bod_en_o), .adc_start_o(adc_start_o),
        .asleep_o(asleep_o), .bod_sleep_o(bod_sleep_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase 0 awake, 1 asleep, 2 settling
    int  m_phase = 0, m_mode = 0, m_left = 0, m_win = 0, m_run = 0;
    bit  m_off = 0, m_bods = 0, m_pulse = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_mode = 0; m_left = 0; m_win = 0; m_run = 0;
            m_off = 0; m_bods = 0; m_pulse = 0;
        end else begin
            bit [7:0] allow;
            bit [7:0] live;
            bit lvl_ok;
            lvl_ok = wake_req_i[6] && (m_run + 1 >= HOLD);
            m_run = wake_req_i[6] ? m_run + 1 : 0;
            live = wake_req_i;
            live[6] = lvl_ok;
            allow = (m_mode == 0) ? 8'hFF : (m_mode == 1) ? 8'hFE : 8'hCC;
            m_pulse = 0;
            if (m_phase == 0) begin
                if (sleep_strobe_i && sleep_en_i) begin
                    m_phase = 1;
                    m_mode = (mode_i == 3'd1) ? 1 : (mode_i == 3'd2) ? 2 : 0;
                    m_off = m_bods;
                    m_pulse = adc_enabled_i && (m_mode != 2);
                end
            end else if (m_phase == 1) begin
                if ((live & allow) != 0) begin
                    if (m_off) begin m_phase = 2; m_left = SETTLE; end
                    else m_phase = 0;
                end
            end else begin
                m_left--;
                if (m_left == 0) m_phase = 0;
            end
            if (bods_wr_i) begin
                if (bods_unlock_i) m_win = 4;
                else begin
                    if (m_win > 0) m_bods = bods_val_i;
                    m_win = 0;
                end
            end else if (m_win > 0) m_win--;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit awake;
            awake = (m_phase == 0);
            chk(clk_en_cpu_o == awake && clk_en_flash_o == awake, "R2/R3/R4 cpu+flash",
                clk_en_cpu_o, awake);
            chk(clk_en_io_o == (awake || m_mode == 0), "R2/R3 io", clk_en_io_o,
                awake || m_mode == 0);
            chk(clk_en_adc_o == (awake || m_mode != 2), "R3/R4 adc", clk_en_adc_o,
                awake || m_mode != 2);
            chk(bod_en_o == !(m_phase == 1 && m_off), "R8 bod_en", bod_en_o,
                !(m_phase == 1 && m_off));
            chk(adc_start_o == m_pulse, "R7 adc_start", adc_start_o, m_pulse);
            chk(asleep_o == !awake, "R9 asleep", asleep_o, !awake);
            chk(bod_sleep_o == m_bods, "R10 bod_sleep", bod_sleep_o, m_bods);
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic go_sleep(input logic [2:0] code);
        mode_i = code; sleep_en_i = 1; sleep_strobe_i = 1;
        tick();
        sleep_strobe_i = 0;
    endtask

    task automatic pulse_wake(input int bitn, input int len);
        wake_req_i[bitn] = 1;
        tick(len);
        wake_req_i[bitn] = 0;
        tick();
    endtask

    task automatic bods_write(input bit unl, input bit v);
        bods_wr_i = 1; bods_unlock_i = unl; bods_val_i = v;
        tick();
        bods_wr_i = 0; bods_unlock_i = 0; bods_val_i = 0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !done) begin
                done = 1;
                fails++; tests++;
                $display("FAIL watchdog actual=%0d expected=<20000", cycles);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        int n;
        tick(3);
        rst_n = 1;
        #1;
        // R1 reset state
        chk(clk_en_cpu_o && clk_en_flash_o && clk_en_io_o && clk_en_adc_o && bod_en_o &&
            !asleep_o && !bod_sleep_o, "R1 reset state", asleep_o, 0);
        tick(2);

        // R5 strobe with enable low
        mode_i = 3'd2; sleep_en_i = 0; sleep_strobe_i = 1;
        tick();
        sleep_strobe_i = 0;
        chk(clk_en_cpu_o == 1, "R5 strobe without enable", clk_en_cpu_o, 1);
        tick(2);

        // R2 idle with ADC start, wake by generic interrupt
        adc_enabled_i = 1;
        go_sleep(3'd0);
        chk(!clk_en_cpu_o && clk_en_io_o && adc_start_o, "R2 idle entry", clk_en_io_o, 1);
        go_sleep(3'd1);  // R5 strobe while asleep ignored
        chk(clk_en_io_o == 1, "R5 strobe while asleep", clk_en_io_o, 1);
        pulse_wake(0, 1);
        chk(clk_en_cpu_o == 1, "R9 idle wake", clk_en_cpu_o, 1);
        tick(2);

        // R2 reserved code acts as idle, R6 ADC done wakes
        go_sleep(3'd5);
        chk(clk_en_io_o == 1, "R2 reserved code", clk_en_io_o, 1);
        pulse_wake(1, 1);
        tick(2);

        // R3 ADC quiet, generic irq ignored, ADC done wakes
        go_sleep(3'd1);
        pulse_wake(0, 2);
        chk(asleep_o == 1, "R6 adc-quiet ignores bit0", asleep_o, 1);
        pulse_wake(1, 1);
        chk(asleep_o == 0, "R6 adc-quiet wakes on bit1", asleep_o, 0);
        tick(2);

        // R4 power down, R7 no ADC start
        go_sleep(3'd2);
        chk(adc_start_o == 0 && clk_en_adc_o == 0, "R7 no start in power-down", adc_start_o, 0);
        pulse_wake(0, 1); pulse_wake(1, 1); pulse_wake(4, 1); pulse_wake(5, 1);
        chk(asleep_o == 1, "R6 power-down ignores 0/1/4/5", asleep_o, 1);
        pulse_wake(7, 1);
        chk(asleep_o == 0, "R6 power-down pin change", asleep_o, 0);
        tick(2);

        // R11 level hold
        go_sleep(3'd2);
        pulse_wake(6, HOLD - 1);
        chk(asleep_o == 1, "R11 short level ignored", asleep_o, 1);
        pulse_wake(6, HOLD);
        chk(asleep_o == 0, "R11 held level wakes", asleep_o, 0);
        tick(2);

        // R10 timed write
        bods_write(1, 0); tick(5); bods_write(0, 1);
        chk(bod_sleep_o == 0, "R10 late write ignored", bod_sleep_o, 0);
        bods_write(0, 1);
        chk(bod_sleep_o == 0, "R10 write without unlock", bod_sleep_o, 0);
        bods_write(1, 0); tick(3); bods_write(0, 1);
        chk(bod_sleep_o == 1, "R10 write at window edge", bod_sleep_o, 1);
        tick(2);

        // R8 brown-out off during sleep then settling
        go_sleep(3'd2);
        chk(bod_en_o == 0, "R8 bod off asleep", bod_en_o, 0);
        wake_req_i[2] = 1;
        n = 0;
        tick();
        wake_req_i[2] = 0;
        chk(bod_en_o == 1, "R8 bod back on wake", bod_en_o, 1);
        while (!clk_en_cpu_o && n < 100) begin
            n++;
            if (n == 5) wake_req_i[7] = 1;
            tick();
        end
        wake_req_i[7] = 0;
        chk(n == SETTLE, "R8 settle length", n, SETTLE);
        tick(2);

        // R9 immediate wake after clearing the bit
        bods_write(1, 0); bods_write(0, 0);
        chk(bod_sleep_o == 0, "R10 clear", bod_sleep_o, 0);
        go_sleep(3'd1);
        wake_req_i[3] = 1;
        tick();
        wake_req_i[3] = 0;
        chk(clk_en_cpu_o == 1, "R9 no settle delay", clk_en_cpu_o, 1);
        tick(3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule